// File: doc/BRIEF.md
# Set-Associative Write-Back Cache with LRU Replacement

This block sits between a processor-side load/store port and a slower block-wide memory port. It holds copies of memory blocks in a K-way set-associative array, with two ways by default. Each way of a set keeps a valid flag, a dirty flag, a tag and one block of data. The block's address picks one set, and the tags of every way in that set are compared at once. A read hit returns the addressed word with no memory traffic. A write hit changes only the cached copy and marks that way dirty.

On a miss the processor port stalls and a victim way is picked in the indexed set. An empty way is taken first. If every way is full, the way used least recently is taken. A dirty victim is first sent to memory at the address made from its own tag and the set index. The requested block is then read in, marked clean and valid, and the access is retried, so it completes as a hit. The memory side moves one whole block per request/acknowledge handshake.

Top module: `assoc_wb_cache`

## Requirements
- R1: The word address splits into three fields. The low OFF_W bits give the word within the block, with word 0 in bits [DATA_W-1:0] of a block. The next IDX_W bits give the set. The remaining upper bits are the tag. The memory block address is the word address without its offset bits.
- R2: A read whose block is present raises cpu_ready in the same cycle as cpu_req, returns the addressed word on cpu_rdata, and causes no memory transaction.
- R3: At most one way of the indexed set matches the address. A hit requires that way's valid flag and a tag equal to the address tag.
- R4: On a miss the access stalls while the block is read from memory at its block address. The block is then installed as valid and clean, and the retried access completes as a hit in the cycle after the fill acknowledge.
- R5: A write hit replaces the addressed word in the cached block, sets that way's dirty flag, and causes no memory transaction.
- R6: When the victim is dirty, it is written to memory at {victim tag, set index} with its cached data, and that write completes before the fill read starts. A clean victim causes no memory write.
- R7: An invalid way in the set is always taken as victim before any valid way.
- R8: When every way is valid, the victim is the way whose last hit or fill lies furthest in the past. In a 4-set, 2-way cache, the block trace 0, 6, 4, 0, 8 evicts block 4 and keeps block 0.
- R9: In a 4-set, 2-way cache, the alternating block trace 0, 8, 0, 8, ... misses on its first two accesses only.
- R10: Once mem_req is raised, it stays high with mem_addr and mem_we unchanged until mem_ack is seen. mem_wdata holds the victim block throughout a write.
- R11: After reset every way is invalid, mem_req is low, and cpu_ready is low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory block transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block fill |
| mem_addr | output | ADDR_W-OFF_W | Memory block address |
| mem_wdata | output | DATA_W*BLK_WORDS | Block being written back |
| mem_rdata | input | DATA_W*BLK_WORDS | Fill block, valid with mem_ack |
| mem_ack | input | 1 | One-cycle pulse ending the current transfer |

## Verification
The assertions assume that the processor side holds cpu_req, cpu_we, cpu_addr and cpu_wdata unchanged from the cycle a request is raised until the edge where cpu_ready is high. They also assume that mem_ack is a single-cycle pulse given only while mem_req is high. The restart check depends on both: it expects a hit in the cycle after a fill only because the request is still presented. The bench issues every access from one task that holds the inputs until completion. Its memory model raises a single acknowledge per request after a fixed delay and ignores the request in the acknowledge cycle. Random addresses are drawn from a small pool of blocks so that conflicts, write-backs and LRU choices occur often.

// File: rtl/assoc_wb_cache.sv
module assoc_wb_cache #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int BLK_WORDS = 2,
  parameter int SETS      = 4,
  parameter int WAYS      = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_req,
  input  logic                        cpu_we,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [DATA_W-1:0]           cpu_wdata,
  output logic [DATA_W-1:0]           cpu_rdata,
  output logic                        cpu_ready,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [ADDR_W-$clog2(BLK_WORDS)-1:0] mem_addr,
  output logic [DATA_W*BLK_WORDS-1:0] mem_wdata,
  input  logic [DATA_W*BLK_WORDS-1:0] mem_rdata,
  input  logic                        mem_ack
);
  localparam int OFF_W = $clog2(BLK_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int BLK_W = DATA_W * BLK_WORDS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL} st_t;
  st_t state;

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [BLK_W-1:0] data_q  [SETS][WAYS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];
  logic [WAY_W-1:0] victim_q;

  wire [IDX_W-1:0] idx = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0] off = cpu_addr[OFF_W-1:0];

  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] vic_way;
  logic             vic_found;
  logic             hit;

  always_comb begin
    hit_way   = '0;
    vic_way   = '0;
    vic_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[idx][w] && (tag_q[idx][w] == tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    for (int w = 0; w < WAYS; w++)
      if (!valid_q[idx][w] && !vic_found) begin
        vic_way   = WAY_W'(w);
        vic_found = 1'b1;
      end
    if (!vic_found)
      for (int w = 0; w < WAYS; w++)
        if (age_q[idx][w] == WAY_W'(WAYS-1)) vic_way = WAY_W'(w);
  end

  assign hit       = |hit_vec;
  assign cpu_ready = (state == ST_IDLE) && cpu_req && hit;
  assign cpu_rdata = data_q[idx][hit_way][off*DATA_W +: DATA_W];
  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_WB);
  assign mem_addr  = (state == ST_WB) ? {tag_q[idx][victim_q], idx} : cpu_addr[ADDR_W-1:OFF_W];
  assign mem_wdata = data_q[idx][victim_q];

  wire              fill_done = (state == ST_FILL) && mem_ack;
  wire              touch     = cpu_ready || fill_done;
  wire [WAY_W-1:0]  touch_way = cpu_ready ? hit_way : victim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      victim_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      case (state)
        ST_IDLE:
          if (cpu_req) begin
            if (hit) begin
              if (cpu_we) begin
                data_q[idx][hit_way][off*DATA_W +: DATA_W] <= cpu_wdata;
                dirty_q[idx][hit_way] <= 1'b1;
              end
            end else begin
              victim_q <= vic_way;
              state    <= (valid_q[idx][vic_way] && dirty_q[idx][vic_way]) ? ST_WB : ST_FILL;
            end
          end
        ST_WB:
          if (mem_ack) state <= ST_FILL;
        default:
          if (mem_ack) begin
            data_q[idx][victim_q]  <= mem_rdata;
            tag_q[idx][victim_q]   <= tag;
            valid_q[idx][victim_q] <= 1'b1;
            dirty_q[idx][victim_q] <= 1'b0;
            state                  <= ST_IDLE;
          end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++)
        if (WAY_W'(w) == touch_way) age_q[idx][w] <= '0;
        else if (age_q[idx][w] < age_q[idx][touch_way]) age_q[idx][w] <= age_q[idx][w] + 1'b1;
    end
  end

  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r4_restart_hits: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> cpu_ready);

  a_r5_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |=> dirty_q[$past(idx)][$past(hit_way)]);

  a_r6_wb_before_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/assoc_wb_cache_tb.sv
`timescale 1ns/1ps
module assoc_wb_cache_tb;
  localparam int ADDR_W = 10, DATA_W = 32, BW = 2, BA_W = 9, BLK_W = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready, mem_req, mem_we, mem_ack;
  logic [BA_W-1:0] mem_addr;
  logic [BLK_W-1:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  assoc_wb_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  logic [BLK_W-1:0] mem [1 << BA_W];
  logic [DATA_W-1:0] ref_mem [1 << ADDR_W];
  int rd_cnt = 0, wr_cnt = 0, dly = 0;
  int last_wr_addr = -1;
  int tests = 0, fails = 0, cyc = 0;

  function automatic logic [DATA_W-1:0] init_word(int a);
    return (DATA_W'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  initial begin
    for (int b = 0; b < (1 << BA_W); b++) mem[b] = {init_word(2*b+1), init_word(2*b)};
    for (int a = 0; a < (1 << ADDR_W); a++) ref_mem[a] = init_word(a);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; dly <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; dly <= 0;
    end else if (mem_req) begin
      if (dly == 2) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; last_wr_addr <= int'(mem_addr);
        end else begin
          mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1;
        end
      end else dly <= dly + 1;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cpu_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic access(input bit we, input int a, input logic [DATA_W-1:0] wd,
                        output logic [DATA_W-1:0] rd, output bit miss);
    int r0;
    r0 = rd_cnt;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(a); cpu_wdata = wd;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0;
    miss = (rd_cnt != r0);
    if (we) ref_mem[a] = wd;
  endtask

  task automatic rd_blk(int blk, string req, bit exp_miss);
    logic [DATA_W-1:0] d; bit m;
    access(1'b0, blk*BW, '0, d, m);
    check(req, 64'(m), 64'(exp_miss));
    check(req, 64'(d), 64'(ref_mem[blk*BW]));
  endtask

  initial begin
    logic [DATA_W-1:0] d;
    bit m;
    int w0;
    logic [DATA_W-1:0] v;
    void'($urandom(32'd7));
    do_reset();
    check("R11 ready idle", 64'(cpu_ready), 64'd0);
    check("R11 mem_req idle", 64'(mem_req), 64'd0);

    // R9: alternating 0,8
    rd_blk(0, "R9 first miss", 1'b1);
    rd_blk(8, "R9 second miss", 1'b1);
    for (int i = 0; i < 2; i++) begin
      rd_blk(0, "R9 hit 0", 1'b0);
      rd_blk(8, "R9 hit 8", 1'b0);
    end

    // R8 / R7: trace 0,6,4,0,8
    do_reset();
    rd_blk(0, "R8 trace 0", 1'b1);
    rd_blk(6, "R8 trace 6", 1'b1);
    rd_blk(4, "R7 trace 4 into free way", 1'b1);
    rd_blk(0, "R7 trace 0 kept", 1'b0);
    rd_blk(8, "R8 trace 8", 1'b1);
    rd_blk(0, "R8 block 0 retained", 1'b0);
    rd_blk(4, "R8 block 4 evicted", 1'b1);

    // R5 / R6 / R10: dirty path in set 1
    do_reset();
    access(1'b0, 3, '0, d, m);
    check("R4 fill miss", 64'(m), 64'd1);
    check("R1 offset word", 64'(d), 64'(ref_mem[3]));
    w0 = wr_cnt;
    v = 32'hC0FFEE11;
    access(1'b1, 3, v, d, m);
    check("R5 write hit no fill", 64'(m), 64'd0);
    check("R5 write hit no mem write", 64'(wr_cnt), 64'(w0));
    access(1'b0, 3, '0, d, m);
    check("R2 read hit data", 64'(d), 64'(v));
    check("R2 read hit no mem", 64'(m), 64'd0);
    rd_blk(5, "R7 second way", 1'b1);
    check("R6 clean fill no write", 64'(wr_cnt), 64'(w0));
    rd_blk(9, "R6 evicting dirty", 1'b1);
    check("R6 write-back count", 64'(wr_cnt), 64'(w0 + 1));
    check("R6 write-back address", 64'(last_wr_addr), 64'd1);
    check("R10 written block data", 64'(mem[1]), {32'(v), 32'(ref_mem[2])});
    rd_blk(13, "R6 clean victim", 1'b1);
    check("R6 clean victim no write", 64'(wr_cnt), 64'(w0 + 1));

    // random mix against reference memory
    for (int i = 0; i < 400; i++) begin
      int a;
      bit we;
      a = int'($urandom % 16) * BW + int'($urandom % BW);
      we = ($urandom % 3) == 0;
      if (we) access(1'b1, a, $urandom, d, m);
      else begin
        access(1'b0, a, '0, d, m);
        check("R3 R4 random read", 64'(d), 64'(ref_mem[a]));
      end
    end
    for (int a = 0; a < 32; a++) begin
      access(1'b0, a, '0, d, m);
      check("R1 final sweep", 64'(d), 64'(ref_mem[a]));
    end

    summary();
    $finish;
  end
endmodule